// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a 512-word by 18-bit first-in first-out buffer between two clock domains. Words enter on rising edges of the load clock `ldck` when `ld_en` is high. They leave on rising edges of the unload clock `unck` when `un_en` is high. The two clocks may be unrelated or identical. The read side is first-word fall-through: the oldest stored word is always present on `q`, and an unload edge discards it to reveal the next one. A high `oe_n` puts `q` into high impedance.

Four status outputs are provided, all with fixed polarities:
- `full_n` is active low.
- `empty_n` is active low.
- `half_full` is high at 256 or more words.
- `almost_flag` is high in either of two regions: at or below a lower offset X, or at or above 512 minus an upper offset Y.

The offsets are loaded in-band. After reset, a small state machine in the load domain waits in `WAIT_X`. An enabled load edge with `pen_n` low captures X from `din[8:0]` and moves to `WAIT_Y`. The next such edge captures Y and moves to `RUN`. In `WAIT_Y`, an enabled edge with `pen_n` high copies X into Y and moves to `RUN`, and that edge stores a word. In `WAIT_X`, an enabled edge with `pen_n` high keeps the default offsets of 32 and moves to `RUN`, and that edge also stores a word. `RUN` is left only by reset.

The pointers are 10-bit Gray counters. Each crosses into the other domain through a two-flop synchronizer. `full_n`, `half_full` and `almost_flag` come from the load domain. `empty_n` comes from the unload domain.

Top module: `ffq_dual_clk_fifo`

## Requirements
- R1: Words leave in the order they were accepted, with all 18 bits intact, under independent load and unload traffic.
- R2: `full_n` is 0 exactly when 512 words are held. A load edge while `full_n` is 0 changes neither the stored words nor the count.
- R3: `empty_n` is 0 when no word is held. An unload edge while `empty_n` is 0 removes nothing, so the next word loaded is the one that appears.
- R4: `half_full` is 0 at 255 words and 1 at 256 words, and it is 1 whenever the buffer is full.
- R5: With offsets X and Y, `almost_flag` is 1 at X words or fewer and at 512-Y words or more, and 0 from X+1 to 511-Y words.
- R6: With `pen_n` low after reset, the first two enabled load edges take X and then Y from `din[8:0]` (upper bits ignored), and neither edge stores a word.
- R7: If only one programming edge occurs, Y equals X. If none occurs, both offsets are 32. Once in `RUN`, the state machine stays there until reset.
- R8: With `rst_n` low, `full_n`=1, `empty_n`=0, `half_full`=0 and `almost_flag`=1.
- R9: The first word loaded into an empty buffer raises `empty_n` and appears on `q` with no unload edge.
- R10: With `oe_n` high, every bit of `q` is high impedance.
- R11: Each Gray pointer changes by at most one bit per edge of its own clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ldck | input | 1 | Load clock |
| unck | input | 1 | Unload clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| pen_n | input | 1 | Active-low offset programming enable |
| ld_en | input | 1 | Load request, sampled on `ldck` |
| din | input | 18 | Data word, or offset in bits 8:0 while programming |
| un_en | input | 1 | Unload request, sampled on `unck` |
| oe_n | input | 1 | Active-low output enable for `q` |
| q | output | 18 | Oldest stored word (first-word fall-through) |
| full_n | output | 1 | Low when 512 words are held |
| empty_n | output | 1 | Low when no word is held |
| half_full | output | 1 | High at 256 or more words |
| almost_flag | output | 1 | High in the almost-empty or almost-full region |

## Verification
The assertions assume that `rst_n` is held low across at least one edge of each clock before traffic starts. They also assume that `ld_en`, `un_en`, `pen_n` and `din` change only away from the rising edge of the clock that samples them.

The bench meets these assumptions by driving every input on the falling edge of its own clock. It keeps both requests low while reset is asserted.

Flag checks are taken only after a few idle cycles of both clocks, so the synchronizer lag has passed and the flags reflect the true occupancy.

// File: rtl/ffq_pkg.sv
package ffq_pkg;
    typedef enum logic [1:0] {
        PG_WAIT_X = 2'd0,
        PG_WAIT_Y = 2'd1,
        PG_RUN    = 2'd2
    } prog_state_e;
endpackage

// File: rtl/ffq_sync2.sv
module ffq_sync2 #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/ffq_g2b.sv
module ffq_g2b #(
    parameter int W = 10
) (
    input  logic [W-1:0] gray,
    output logic [W-1:0] bin
);
    always_comb begin
        bin[W-1] = gray[W-1];
        for (int i = W - 2; i >= 0; i--) begin
            bin[i] = bin[i+1] ^ gray[i];
        end
    end
endmodule

// File: rtl/ffq_gray_ptr.sv
module ffq_gray_ptr #(
    parameter int PW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    output logic [PW-1:0] bin,
    output logic [PW-1:0] gray
);
    logic [PW-1:0] bin_nxt;

    assign bin_nxt = bin + PW'(inc);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bin  <= '0;
            gray <= '0;
        end else begin
            bin  <= bin_nxt;
            gray <= bin_nxt ^ (bin_nxt >> 1);
        end
    end

    // R11: only one bit of the crossing pointer moves per edge
    a_r11_gray_step: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(gray ^ $past(gray)) <= 1);
endmodule

// File: rtl/ffq_prog_ctrl.sv
module ffq_prog_ctrl
    import ffq_pkg::*;
#(
    parameter int OW      = 9,
    parameter int DEF_OFF = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_en,
    input  logic          pen_n,
    input  logic [OW-1:0] off_in,
    output logic          capture,
    output logic [OW-1:0] off_lo,
    output logic [OW-1:0] off_hi
);
    prog_state_e state, state_nxt;

    assign capture = ld_en && !pen_n && (state != PG_RUN);

    always_comb begin
        state_nxt = state;
        unique case (state)
            PG_WAIT_X: if (ld_en) state_nxt = pen_n ? PG_RUN : PG_WAIT_Y;
            PG_WAIT_Y: if (ld_en) state_nxt = PG_RUN;
            PG_RUN:    state_nxt = PG_RUN;
            default:   state_nxt = PG_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PG_WAIT_X;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_lo <= OW'(DEF_OFF);
            off_hi <= OW'(DEF_OFF);
        end else begin
            unique case (state)
                PG_WAIT_X: if (capture) off_lo <= off_in;
                PG_WAIT_Y: begin
                    if (capture)    off_hi <= off_in;
                    else if (ld_en) off_hi <= off_lo;
                end
                default: ;
            endcase
        end
    end

    // R7: the run state is left only by reset
    a_r7_run_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PG_RUN) |=> (state == PG_RUN));
endmodule

// File: rtl/ffq_dual_clk_fifo.sv
module ffq_dual_clk_fifo #(
    parameter int DW      = 18,
    parameter int DEPTH   = 512,
    parameter int DEF_OFF = 32
) (
    input  logic          ldck,
    input  logic          unck,
    input  logic          rst_n,
    input  logic          pen_n,
    input  logic          ld_en,
    input  logic [DW-1:0] din,
    input  logic          un_en,
    input  logic          oe_n,
    output logic [DW-1:0] q,
    output logic          full_n,
    output logic          empty_n,
    output logic          half_full,
    output logic          almost_flag
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;
    localparam logic [PW-1:0] HALF_V  = PW'(DEPTH / 2);
    localparam logic [PW-1:0] DEPTH_V = PW'(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wbin, wgray, rbin, rgray;
    logic [PW-1:0] wgray_s, rgray_s, rbin_s, wcount, hi_thr;
    logic [AW-1:0] off_lo, off_hi;
    logic          capture, wr_go, rd_go;

    ffq_prog_ctrl #(.OW(AW), .DEF_OFF(DEF_OFF)) u_prog (
        .clk(ldck), .rst_n(rst_n), .ld_en(ld_en), .pen_n(pen_n),
        .off_in(din[AW-1:0]), .capture(capture),
        .off_lo(off_lo), .off_hi(off_hi)
    );

    ffq_gray_ptr #(.PW(PW)) u_wptr (
        .clk(ldck), .rst_n(rst_n), .inc(wr_go), .bin(wbin), .gray(wgray)
    );

    ffq_gray_ptr #(.PW(PW)) u_rptr (
        .clk(unck), .rst_n(rst_n), .inc(rd_go), .bin(rbin), .gray(rgray)
    );

    ffq_sync2 #(.W(PW)) u_r2w (.clk(ldck), .rst_n(rst_n), .d(rgray), .q(rgray_s));
    ffq_sync2 #(.W(PW)) u_w2r (.clk(unck), .rst_n(rst_n), .d(wgray), .q(wgray_s));

    ffq_g2b #(.W(PW)) u_rconv (.gray(rgray_s), .bin(rbin_s));

    // load domain
    assign full_n = !(wgray == {~rgray_s[PW-1:PW-2], rgray_s[PW-3:0]});
    assign wr_go  = ld_en && !capture && full_n;

    always_ff @(posedge ldck) begin
        if (wr_go) mem[wbin[AW-1:0]] <= din;
    end

    assign wcount      = wbin - rbin_s;
    assign hi_thr      = DEPTH_V - PW'(off_hi);
    assign half_full   = (wcount >= HALF_V);
    assign almost_flag = (wcount <= PW'(off_lo)) || (wcount >= hi_thr);

    // unload domain
    assign empty_n = (rgray != wgray_s);
    assign rd_go   = un_en && empty_n;
    assign q       = oe_n ? {DW{1'bz}} : mem[rbin[AW-1:0]];

    // R2: occupancy never exceeds the depth, and full is seen at the depth
    a_r2_count_bound: assert property (@(posedge ldck) disable iff (!rst_n)
        wcount <= DEPTH_V);
    a_r2_full_at_depth: assert property (@(posedge ldck) disable iff (!rst_n)
        (wcount == DEPTH_V) |-> !full_n);
    a_r2_no_overflow: assert property (@(posedge ldck) disable iff (!rst_n)
        (!full_n && ld_en) |=> $stable(wbin));
    // R3: nothing is removed while empty
    a_r3_no_underflow: assert property (@(posedge unck) disable iff (!rst_n)
        !empty_n |=> $stable(rbin));
    // R4 and R5: a full buffer lies in both upper regions
    a_r4_hf_when_full: assert property (@(posedge ldck) disable iff (!rst_n)
        !full_n |-> half_full);
    a_r5_flag_when_full: assert property (@(posedge ldck) disable iff (!rst_n)
        !full_n |-> almost_flag);
    // R6: a programming edge stores no word
    a_r6_prog_no_store: assert property (@(posedge ldck) disable iff (!rst_n)
        capture |=> $stable(wbin));
endmodule

// File: tb/tb_ffq_dual_clk_fifo.sv
module tb_ffq_dual_clk_fifo;
    localparam int CLK_PERIOD = 10;
    localparam int UN_PERIOD  = CLK_PERIOD * 7 / 5;

    logic        ldck = 0, unck = 0, rst_n = 0;
    logic        pen_n = 1, ld_en = 0, un_en = 0, oe_n = 1;
    logic [17:0] din = '0;
    logic [17:0] q;
    logic        full_n, empty_n, half_full, almost_flag;

    int nchk = 0, nerr = 0, pops = 0;
    bit finished = 0, wdone = 0;
    logic [17:0] model[$];
    logic [17:0] seq = 18'h100;

    always #(CLK_PERIOD/2) ldck = ~ldck;
    always #(UN_PERIOD/2)  unck = ~unck;

    ffq_dual_clk_fifo dut (
        .ldck(ldck), .unck(unck), .rst_n(rst_n), .pen_n(pen_n), .ld_en(ld_en),
        .din(din), .un_en(un_en), .oe_n(oe_n), .q(q), .full_n(full_n),
        .empty_n(empty_n), .half_full(half_full), .almost_flag(almost_flag)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 0; ld_en = 0; un_en = 0; pen_n = 1;
        repeat (3) @(negedge unck);
        model.delete();
        @(negedge ldck);
        rst_n = 1;
    endtask

    task automatic settle();
        repeat (4) @(negedge unck);
        repeat (4) @(negedge ldck);
    endtask

    task automatic write_word(input logic [17:0] d);
        @(negedge ldck);
        ld_en = 1; din = d;
        if (full_n) model.push_back(d);
        @(negedge ldck);
        ld_en = 0;
    endtask

    task automatic fill_to(input int n);
        while (model.size() < n) begin
            seq = seq + 18'd1;
            write_word(seq);
        end
    endtask

    task automatic read_one();
        @(negedge unck);
        if (empty_n) begin
            if (model.size() == 0) chk("R3 empty_n high with nothing stored", 1, 0);
            else begin
                chk("R1 word order", q, model[0]);
                void'(model.pop_front());
                pops++;
            end
        end
        un_en = 1;
        @(negedge unck);
        un_en = 0;
    endtask

    task automatic program_two(input logic [17:0] x, input logic [17:0] y);
        @(negedge ldck);
        pen_n = 0; ld_en = 1; din = x;
        @(negedge ldck);
        din = y;
        @(negedge ldck);
        ld_en = 0; pen_n = 1;
    endtask

    initial begin
        repeat (150000) @(posedge ldck);
        if (!finished) begin
            nerr++;
            $display("FAIL watchdog (all R) actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        // R8 / R10: reset state and disabled outputs
        repeat (2) @(negedge ldck);
        chk("R8 full_n in reset", full_n, 1);
        chk("R8 empty_n in reset", empty_n, 0);
        chk("R8 half_full in reset", half_full, 0);
        chk("R8 almost_flag in reset", almost_flag, 1);
        chk("R10 q high impedance", 32'(q === {18{1'bz}}), 1);
        do_reset();
        oe_n = 0;

        // R6: X=4, Y=8 from low 9 bits, upper bits set
        program_two(18'h3FE04, 18'h2A008);
        fill_to(4); settle();
        chk("R5 flag at X", almost_flag, 1);
        chk("R9 first word without unload", q, model[0]);
        chk("R9 empty_n after first word", empty_n, 1);
        fill_to(5); settle();
        chk("R5 flag at X+1", almost_flag, 0);
        fill_to(255); settle();
        chk("R4 half_full at 255", half_full, 0);
        fill_to(256); settle();
        chk("R4 half_full at 256", half_full, 1);
        fill_to(503); settle();
        chk("R5 flag at 511-Y", almost_flag, 0);
        fill_to(504); settle();
        chk("R5 flag at 512-Y", almost_flag, 1);
        fill_to(511); settle();
        chk("R2 full_n at 511", full_n, 1);
        fill_to(512); settle();
        chk("R2 full_n at 512", full_n, 0);
        chk("R4 half_full when full", half_full, 1);
        write_word(18'h3ABCD);
        settle();
        chk("R2 head unchanged after write while full", q, model[0]);
        pops = 0;
        while (model.size() > 0) read_one();
        chk("R2 R6 words drained", pops, 512);
        settle();
        chk("R3 empty_n after drain", empty_n, 0);
        repeat (3) read_one();
        write_word(18'h15A5A);
        settle();
        chk("R3 empty_n after one word", empty_n, 1);
        chk("R3 word after reads while empty", q, 18'h15A5A);
        read_one(); settle();
        chk("R3 empty again", empty_n, 0);

        // R7: single programming edge, Y=X=10
        do_reset();
        @(negedge ldck); pen_n = 0; ld_en = 1; din = 18'h1000A;
        @(negedge ldck); ld_en = 0; pen_n = 1;
        fill_to(10); settle();
        chk("R7 single edge flag at 10", almost_flag, 1);
        fill_to(11); settle();
        chk("R7 single edge flag at 11", almost_flag, 0);
        fill_to(501); settle();
        chk("R7 single edge flag at 501", almost_flag, 0);
        fill_to(502); settle();
        chk("R7 single edge flag at 502", almost_flag, 1);
        chk("R6 head is first data word", q, model[0]);

        // R7: no programming, defaults 32
        do_reset();
        fill_to(32); settle();
        chk("R7 default flag at 32", almost_flag, 1);
        fill_to(33); settle();
        chk("R7 default flag at 33", almost_flag, 0);
        fill_to(479); settle();
        chk("R7 default flag at 479", almost_flag, 0);
        fill_to(480); settle();
        chk("R7 default flag at 480", almost_flag, 1);

        // R1: concurrent traffic
        do_reset();
        fork
            begin
                for (int i = 0; i < 1500; i++) begin
                    repeat ($urandom_range(0, 2)) @(negedge ldck);
                    write_word(18'($urandom));
                end
                wdone = 1;
            end
            begin
                while (!(wdone && model.size() == 0)) begin
                    repeat ($urandom_range(0, 1)) @(negedge unck);
                    read_one();
                end
            end
        join
        settle();
        chk("R1 empty after traffic", empty_n, 0);
        oe_n = 1;
        @(negedge unck);
        chk("R10 q high impedance again", 32'(q === {18{1'bz}}), 1);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule